// File: doc/BRIEF.md
# Repeater Expansion Port Interface

This block sits at the inter-chip edge of a multi-port Ethernet repeater core clocked at 50 MHz. It places the outgoing 5-bit symbol stream on a shared bidirectional expansion bus. It drives that bus only while an external arbiter grants it, through an active-low enable. It also raises a per-port activity strobe that frames each outgoing packet. The strobe leads the start delimiter by a fixed number of core cycles and trails the end delimiter by a fixed number of cycles. The outgoing symbols pass through a short pipeline so that this lead is met without ever stalling the symbol source.

The block merges the per-port forced-jam requests and the core's collision indication into a single registered jam output. It takes an external jam request and an external carrier-sense signal. Both of these, and the arbiter's enable, pass through a two-flop synchronizer followed by a two-sample glitch filter. A filtered jam request is broadcast to every port. At reset release, the block captures the value strapped on the lower activity pins as the chip's physical address. It keeps those pins undriven until the capture has happened.

Top module: `xp_expansion_port`

## Requirements
- R1: `jam_o` is high in the cycle after any bit of `cim_jam_i` or `coll_i` was high, and low otherwise. `jam_i` has no effect on `jam_o`.
- R2: Once `jam_i` has been held high, `jam_ports_o` becomes all ones exactly 4 clock edges after the first edge that samples it high. A `jam_i` pulse lasting a single cycle leaves `jam_ports_o` at zero.
- R3: `edat_oe_o` is low during and after reset, so the bus is an input by default. It goes high 4 edges after `edat_en_n_i` is sampled low and drops 4 edges after the input is sampled high. A one-cycle high glitch on the enable does not change it.
- R4: A frame's symbols (`tx_sym_i` while `tx_valid_i` is high) appear on `edat_o` in order and unchanged. The first symbol appears exactly LEAD (5) cycles after the activity strobe rises. When no symbol is present, `edat_o` carries the idle code 5'b11111, and sources never send that code inside a frame.
- R5: After the cycle in which the symbol marked by `tx_last_i` is on `edat_o`, the activity strobe stays high for LAG (2) more cycles and then falls.
- R6: During a frame, `act_o` has exactly one bit set, bit `tx_port_i` (a binary index taken at the frame's first symbol). Otherwise `act_o` is zero.
- R7: During reset, `act_lo_oe_o` is low. At the first edge after reset release, `phys_addr_o` captures `act_pin_i` and `act_lo_oe_o` goes high. Later changes on `act_pin_i` are ignored.
- R8: `any_act_o` is the combinational OR of all `act_o` bits and all `txen_i` bits.
- R9: `crs_o` follows `crs_i` through the same filter as R2: 4 edges of latency, and a single-cycle pulse is ignored.
- R10: If a new frame's first symbol follows the previous frame's last symbol with no gap, the activity strobe stays high without a break. Both frames' symbols arrive in order.
- R11: While `edat_oe_o` is low, `rx_sym_o` shows `edat_i` one cycle later. While it is high, `rx_sym_o` shows the idle code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cim_jam_i | input | NPORT | Per-port forced-jam requests from carrier-integrity logic |
| coll_i | input | 1 | Internal collision indication |
| jam_i | input | 1 | External jam request from the arbiter |
| jam_ports_o | output | NPORT | Jam command broadcast to every port |
| jam_o | output | 1 | Merged forced-jam output |
| crs_i | input | 1 | External carrier sense |
| crs_o | output | 1 | Filtered carrier sense |
| edat_en_n_i | input | 1 | Active-low bus drive grant |
| edat_i | input | 5 | Expansion bus value seen at the pins |
| edat_o | output | 5 | Symbol driven toward the bus |
| edat_oe_o | output | 1 | Bus output enable |
| rx_sym_o | output | 5 | Received bus symbol |
| tx_valid_i | input | 1 | Outgoing symbol valid |
| tx_sym_i | input | 5 | Outgoing symbol |
| tx_last_i | input | 1 | Marks the final symbol of a frame or jam burst |
| tx_port_i | input | 3 | Port index of the frame |
| act_pin_i | input | NADDR | Strap value on the lower activity pins |
| act_o | output | NPORT | Per-port activity strobes |
| act_lo_oe_o | output | 1 | Drive enable for the lower NADDR activity pins |
| phys_addr_o | output | NADDR | Captured chip address |
| txen_i | input | NTXEN | Transmit-enable flags included in any-activity |
| any_act_o | output | 1 | OR of all activity and transmit enables |

## Verification
The external jam request and a port's forced-jam request can be active in the same cycle. One must broadcast jam to every port, and the other must raise the merged jam output without letting the external request leak into it. The bench raises `jam_i` and a `cim_jam_i` bit together, then drops only the port request while `jam_i` is held. It then expects `jam_o` to clear one cycle later while `jam_ports_o` stays all ones. A second overlap is provoked by starting a frame in the same cycle that the previous one ends. There the strobe's lag countdown and a new frame's start collide, and the bench judges that the strobe never drops and that every symbol still arrives in order.

// File: rtl/xp_pkg.sv
// Package: shared symbol type and constants for the expansion port.
// Assumes 5-bit line symbols with 5'b11111 used as the idle code.
package xp_pkg;
    localparam int SYM_W = 5;
    typedef logic [SYM_W-1:0] sym_t;
    localparam sym_t IDLE_SYM = 5'b11111;
endpackage

// File: rtl/xp_sync_filter.sv
// Two-flop synchronizer followed by a two-sample glitch filter.
// The output moves only when two consecutive synchronized samples agree.
// Assumes d_i is asynchronous to clk; RST_VAL is the inactive level.
module xp_sync_filter #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic s0_q, s1_q, hist_q, filt_q;

    // Synchronize, keep one sample of history, update on two agreeing samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s0_q   <= RST_VAL;
            s1_q   <= RST_VAL;
            hist_q <= RST_VAL;
            filt_q <= RST_VAL;
        end else begin
            s0_q   <= d_i;
            s1_q   <= s0_q;
            hist_q <= s1_q;
            if (s1_q == hist_q) filt_q <= s1_q;
        end
    end

    assign q_o = filt_q;
endmodule

// File: rtl/xp_frame_tx.sv
// Outgoing frame path: delays symbols LEAD cycles behind the activity
// strobe and holds the strobe LAG cycles past the final symbol.
// Assumes one frame source at a time and no idle codes inside a frame.
module xp_frame_tx
    import xp_pkg::*;
#(
    parameter int NPORT = 8,
    parameter int LEAD  = 5,
    parameter int LAG   = 2,
    localparam int PW   = $clog2(NPORT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_valid_i,
    input  sym_t             tx_sym_i,
    input  logic             tx_last_i,
    input  logic [PW-1:0]    tx_port_i,
    output logic [NPORT-1:0] act_o,
    output sym_t             sym_o
);
    localparam int TAIL = LEAD + 1 + LAG;
    localparam int TW   = $clog2(TAIL + 1);

    logic [LEAD-1:0] pv_q;
    sym_t            ps_q [LEAD];
    logic            act_q;
    logic [PW-1:0]   port_q;
    logic [TW-1:0]   tail_q;
    sym_t            sym_q;

    // Pipeline stage 0 captures the incoming symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv_q[0] <= 1'b0;
            ps_q[0] <= IDLE_SYM;
        end else begin
            pv_q[0] <= tx_valid_i;
            ps_q[0] <= tx_sym_i;
        end
    end

    // Remaining pipeline stages shift the symbol toward the bus.
    for (genvar g = 1; g < LEAD; g++) begin : g_pipe
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pv_q[g] <= 1'b0;
                ps_q[g] <= IDLE_SYM;
            end else begin
                pv_q[g] <= pv_q[g-1];
                ps_q[g] <= ps_q[g-1];
            end
        end
    end

    // Output register: the symbol at the pipe end, or idle.
    always_ff @(posedge clk) begin
        if (!rst_n) sym_q <= IDLE_SYM;
        else        sym_q <= pv_q[LEAD-1] ? ps_q[LEAD-1] : IDLE_SYM;
    end

    // Activity strobe: rises with the first symbol, counts down the tail after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            port_q <= '0;
            tail_q <= '0;
        end else if (tx_valid_i) begin
            if (!act_q) port_q <= tx_port_i;
            act_q  <= 1'b1;
            tail_q <= tx_last_i ? TW'(TAIL) : '0;
        end else if (tail_q == TW'(1)) begin
            act_q  <= 1'b0;
            tail_q <= '0;
        end else if (tail_q != '0) begin
            tail_q <= tail_q - TW'(1);
        end
    end

    // Decode the held port index into per-port strobes.
    for (genvar p = 0; p < NPORT; p++) begin : g_act
        assign act_o[p] = act_q && (port_q == PW'(p));
    end

    assign sym_o = sym_q;
endmodule

// File: rtl/xp_addr_latch.sv
// Captures the strapped chip address at the first edge after reset release
// and enables the shared pins' drivers only after that capture.
// Assumes the straps are stable while reset is asserted.
module xp_addr_latch #(
    parameter int NADDR = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NADDR-1:0] pin_i,
    output logic [NADDR-1:0] addr_o,
    output logic             oe_o
);
    logic [NADDR-1:0] addr_q;
    logic             done_q;

    // One-shot capture of the pins once reset is gone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            addr_q <= pin_i;
            done_q <= 1'b1;
        end
    end

    assign addr_o = addr_q;
    assign oe_o   = done_q;
endmodule

// File: rtl/xp_expansion_port.sv
// Top of the repeater expansion port: jam merge and broadcast, filtered
// arbiter and carrier inputs, framed symbol output, address capture and
// any-activity. Assumes NADDR <= NPORT and a single clock domain for core inputs.
module xp_expansion_port
    import xp_pkg::*;
#(
    parameter int NPORT = 8,
    parameter int NADDR = 5,
    parameter int NTXEN = 3,
    parameter int LEAD  = 5,
    parameter int LAG   = 2,
    localparam int PW   = $clog2(NPORT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] cim_jam_i,
    input  logic             coll_i,
    input  logic             jam_i,
    output logic [NPORT-1:0] jam_ports_o,
    output logic             jam_o,
    input  logic             crs_i,
    output logic             crs_o,
    input  logic             edat_en_n_i,
    input  logic [4:0]       edat_i,
    output logic [4:0]       edat_o,
    output logic             edat_oe_o,
    output logic [4:0]       rx_sym_o,
    input  logic             tx_valid_i,
    input  logic [4:0]       tx_sym_i,
    input  logic             tx_last_i,
    input  logic [PW-1:0]    tx_port_i,
    input  logic [NADDR-1:0] act_pin_i,
    output logic [NPORT-1:0] act_o,
    output logic             act_lo_oe_o,
    output logic [NADDR-1:0] phys_addr_o,
    input  logic [NTXEN-1:0] txen_i,
    output logic             any_act_o
);
    logic jam_f, en_n_f, jam_q;
    sym_t rx_q;

    xp_sync_filter #(.RST_VAL(1'b0)) u_jam_flt (
        .clk(clk), .rst_n(rst_n), .d_i(jam_i), .q_o(jam_f));
    xp_sync_filter #(.RST_VAL(1'b0)) u_crs_flt (
        .clk(clk), .rst_n(rst_n), .d_i(crs_i), .q_o(crs_o));
    xp_sync_filter #(.RST_VAL(1'b1)) u_en_flt (
        .clk(clk), .rst_n(rst_n), .d_i(edat_en_n_i), .q_o(en_n_f));

    xp_frame_tx #(.NPORT(NPORT), .LEAD(LEAD), .LAG(LAG)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .tx_valid_i(tx_valid_i), .tx_sym_i(tx_sym_i),
        .tx_last_i(tx_last_i), .tx_port_i(tx_port_i),
        .act_o(act_o), .sym_o(edat_o));

    xp_addr_latch #(.NADDR(NADDR)) u_addr (
        .clk(clk), .rst_n(rst_n), .pin_i(act_pin_i),
        .addr_o(phys_addr_o), .oe_o(act_lo_oe_o));

    // Merged jam: port requests and collision, never the external request.
    always_ff @(posedge clk) begin
        if (!rst_n) jam_q <= 1'b0;
        else        jam_q <= (|cim_jam_i) | coll_i;
    end

    // Receive register: bus value while not driving, idle otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= IDLE_SYM;
        else        rx_q <= edat_oe_o ? IDLE_SYM : edat_i;
    end

    assign jam_o       = jam_q;
    assign jam_ports_o = {NPORT{jam_f}};
    assign edat_oe_o   = ~en_n_f;
    assign rx_sym_o    = rx_q;
    assign any_act_o   = (|act_o) | (|txen_i);
endmodule

// File: rtl/xp_checker.sv
// Checker for the expansion port, bound to the top module.
// Holds two small counters for the lead and lag windows.
module xp_checker
    import xp_pkg::*;
#(
    parameter int NPORT = 8,
    parameter int NADDR = 5,
    parameter int LEAD  = 5,
    parameter int LAG   = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPORT-1:0] cim_jam_i,
    input logic             coll_i,
    input logic             jam_i,
    input logic [NPORT-1:0] jam_ports_o,
    input logic             jam_o,
    input logic             edat_en_n_i,
    input logic             edat_oe_o,
    input logic [4:0]       edat_o,
    input logic [NPORT-1:0] act_o,
    input logic [NADDR-1:0] act_pin_i,
    input logic             act_lo_oe_o,
    input logic [NADDR-1:0] phys_addr_o
);
    logic [3:0] since_rise, since_data;

    // Cycles the strobe has been high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rise <= '0;
        else if (!(|act_o))        since_rise <= '0;
        else if (since_rise != 4'hF) since_rise <= since_rise + 4'd1;
    end

    // Cycles since a non-idle symbol was on the bus, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_data <= '0;
        else if (edat_o != IDLE_SYM) since_data <= '0;
        else if (since_data != 4'hF) since_data <= since_data + 4'd1;
    end

    assert_jam_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((|cim_jam_i) || coll_i) |=> jam_o);
    assert_jam_clr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !((|cim_jam_i) || coll_i) |=> !jam_o);
    assert_jam_filter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jam_ports_o[0]) |-> ($past(jam_i, 3) && $past(jam_i, 4)));
    assert_drive_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(edat_oe_o) |-> (!$past(edat_en_n_i, 3) && !$past(edat_en_n_i, 4)));
    assert_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(edat_o) == IDLE_SYM) && (edat_o != IDLE_SYM)) |-> (since_rise >= 4'(LEAD)));
    assert_data_framed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (edat_o != IDLE_SYM) |-> (|act_o));
    assert_lag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|act_o) |-> (since_data == 4'(LAG)));
    assert_one_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_o));
    assert_addr_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_lo_oe_o) |-> (phys_addr_o == $past(act_pin_i)));
endmodule

bind xp_expansion_port xp_checker #(
    .NPORT(NPORT), .NADDR(NADDR), .LEAD(LEAD), .LAG(LAG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cim_jam_i(cim_jam_i), .coll_i(coll_i),
    .jam_i(jam_i), .jam_ports_o(jam_ports_o), .jam_o(jam_o),
    .edat_en_n_i(edat_en_n_i), .edat_oe_o(edat_oe_o), .edat_o(edat_o),
    .act_o(act_o), .act_pin_i(act_pin_i), .act_lo_oe_o(act_lo_oe_o),
    .phys_addr_o(phys_addr_o)
);

// File: tb/tb_xp_expansion_port.sv
module tb_xp_expansion_port;
    localparam int NPORT = 8, NADDR = 5, NTXEN = 3, LEAD = 5, LAG = 2;
    localparam logic [4:0] IDLE = 5'b11111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NPORT-1:0] cim_jam_i = '0;
    logic coll_i = 0, jam_i = 0, crs_i = 0, edat_en_n_i = 1;
    logic [4:0] edat_i = '0, tx_sym_i = '0;
    logic tx_valid_i = 0, tx_last_i = 0;
    logic [2:0] tx_port_i = '0;
    logic [NADDR-1:0] act_pin_i = 5'b10110;
    logic [NTXEN-1:0] txen_i = '0;
    logic [NPORT-1:0] jam_ports_o, act_o;
    logic jam_o, crs_o, edat_oe_o, act_lo_oe_o, any_act_o;
    logic [4:0] edat_o, rx_sym_o;
    logic [NADDR-1:0] phys_addr_o;

    xp_expansion_port dut (.*);

    always #4 clk = ~clk;

    int n_tests = 0, n_fail = 0, cyc = 0, rises = 0;
    logic [4:0] exp_q [$];
    int exp_port = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Driver: feeds one frame and pushes each symbol to the scoreboard queue.
    task automatic send_frame(input int port, input int nd);
        logic [4:0] s;
        exp_port = port;
        for (int i = 0; i < nd + 4; i++) begin
            if (i == 0)           s = 5'b11000;
            else if (i == 1)      s = 5'b10001;
            else if (i == nd + 2) s = 5'b01101;
            else if (i == nd + 3) s = 5'b00111;
            else                  s = {1'b0, 4'((i * 3 + port) & 15)};
            @(posedge clk); #2;
            tx_valid_i = 1; tx_sym_i = s; tx_port_i = 3'(port);
            tx_last_i = (i == nd + 3);
            exp_q.push_back(s);
        end
    endtask

    task automatic stop_tx;
        @(posedge clk); #2;
        tx_valid_i = 0; tx_last_i = 0; tx_sym_i = '0;
    endtask

    // Monitor: pops expected symbols and times strobe edges against bus data.
    logic prev_act = 0;
    bit wait_first = 0;
    int t_rise = 0, t_last = 0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if ((|act_o) && !prev_act) begin
                rises++; t_rise = cyc; wait_first = 1;
                check(act_o == (NPORT'(1) << exp_port), "R6 strobe on frame port",
                      int'(act_o), 1 << exp_port);
            end
            if (edat_o != IDLE) begin
                if (wait_first) begin
                    check(cyc - t_rise == LEAD, "R4 lead cycles", cyc - t_rise, LEAD);
                    wait_first = 0;
                end
                if (exp_q.size() == 0) check(0, "R4 unexpected symbol", int'(edat_o), 0);
                else begin
                    logic [4:0] e;
                    e = exp_q.pop_front();
                    check(edat_o == e, "R4 symbol order", int'(edat_o), int'(e));
                end
                t_last = cyc;
            end
            if (!(|act_o) && prev_act)
                check(cyc - t_last == LAG + 1, "R5 lag cycles", cyc - t_last, LAG + 1);
            prev_act = |act_o;
        end
    end

    initial begin
        #(8 * 150000);
        check(0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit seen;
        tick(4);
        check(act_lo_oe_o == 0, "R7 pins undriven in reset", act_lo_oe_o, 0);
        check(edat_oe_o == 0, "R3 bus input in reset", edat_oe_o, 0);
        check(jam_o == 0 && act_o == 0, "R1 reset outputs", jam_o, 0);
        rst_n = 1;
        tick(1);
        check(phys_addr_o == 5'b10110, "R7 address captured", phys_addr_o, 5'b10110);
        check(act_lo_oe_o == 1, "R7 pins driven", act_lo_oe_o, 1);
        act_pin_i = 5'b00001;
        tick(3);
        check(phys_addr_o == 5'b10110, "R7 later pin change ignored", phys_addr_o, 5'b10110);

        // R1 and R2 overlap: port jam and external jam together.
        cim_jam_i = 8'h04; jam_i = 1;
        tick(1);
        check(jam_o == 1, "R1 port jam merged", jam_o, 1);
        tick(2);
        check(jam_ports_o == 0, "R2 latency not yet", int'(jam_ports_o), 0);
        tick(1);
        check(jam_ports_o == 8'hFF, "R2 jam broadcast", int'(jam_ports_o), 8'hFF);
        cim_jam_i = 0;
        tick(1);
        check(jam_o == 0, "R1 external jam excluded", jam_o, 0);
        check(jam_ports_o == 8'hFF, "R2 broadcast held", int'(jam_ports_o), 8'hFF);
        coll_i = 1;
        tick(1);
        check(jam_o == 1, "R1 collision merged", jam_o, 1);
        coll_i = 0; jam_i = 0;
        tick(6);
        check(jam_ports_o == 0 && jam_o == 0, "R2 jam released", int'(jam_ports_o), 0);
        jam_i = 1; tick(1); jam_i = 0;
        seen = 0;
        for (int i = 0; i < 8; i++) begin tick(1); if (jam_ports_o != 0) seen = 1; end
        check(!seen, "R2 single-cycle pulse ignored", seen, 0);

        // R9 carrier sense filter.
        crs_i = 1; tick(3);
        check(crs_o == 0, "R9 latency not yet", crs_o, 0);
        tick(1);
        check(crs_o == 1, "R9 carrier follows", crs_o, 1);
        crs_i = 0; tick(6);
        crs_i = 1; tick(1); crs_i = 0;
        seen = 0;
        for (int i = 0; i < 8; i++) begin tick(1); if (crs_o) seen = 1; end
        check(!seen, "R9 glitch ignored", seen, 0);

        // R11 receive while not driving.
        edat_i = 5'h0A; tick(1);
        check(rx_sym_o == 5'h0A, "R11 receive path", rx_sym_o, 5'h0A);

        // R3 drive grant.
        edat_en_n_i = 0; tick(4);
        check(edat_oe_o == 1, "R3 bus driven after grant", edat_oe_o, 1);
        tick(1);
        check(rx_sym_o == IDLE, "R11 idle while driving", rx_sym_o, IDLE);
        edat_en_n_i = 1; tick(1); edat_en_n_i = 0;
        seen = 0;
        for (int i = 0; i < 8; i++) begin tick(1); if (!edat_oe_o) seen = 1; end
        check(!seen, "R3 enable glitch ignored", seen, 0);

        // R8 any activity.
        txen_i = 3'b010; #1;
        check(any_act_o == 1, "R8 txen sets any", any_act_o, 1);
        txen_i = 0; #1;
        check(any_act_o == 0, "R8 idle clears any", any_act_o, 0);

        // R4/R5/R6 frames on two ports.
        send_frame(3, 6); stop_tx; tick(3);
        check(any_act_o == 1, "R8 activity sets any", any_act_o, 1);
        tick(12);
        send_frame(6, 3); stop_tx; tick(15);

        // R10 back-to-back frames.
        rises = 0;
        send_frame(1, 2); send_frame(1, 4); stop_tx; tick(15);
        check(rises == 1, "R10 strobe unbroken", rises, 1);
        check(exp_q.size() == 0, "R4 all symbols delivered", exp_q.size(), 0);

        edat_en_n_i = 1; tick(5);
        check(edat_oe_o == 0, "R3 bus released", edat_oe_o, 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule